// File: doc/BRIEF.md
# Line-Locked Clock Loop Digital Front End

This block holds the digital half of a clock synthesizer that locks its output clock to a horizontal line reference. One fast clock stands in for the oscillator. A post-divider divides it by 2, 4, 8 or 16 and produces one enable tick per output-clock period. A programmable feedback divider counts those ticks. Its terminal count is the feedback edge. A phase-frequency detector compares that edge with the selected edge of the line reference and produces pump-up and pump-down enables for an external charge pump.

The frame reference can hold the pump idle ("coast") at a chosen level, or the pump can be left enabled at all times. Both sync inputs are synchronized, then re-timed onto the output-clock ticks and sent out again. A lock detector watches the pump pulse widths over consecutive reference periods. It reports lock as a status output and on a separately enabled pin. All inputs are sampled on `clk`. The reset is synchronous and active high.

Top module: `llpll_front`

## Requirements
- R1: The feedback divider emits one `fbMark` pulse every (`fbDivIn` + 8) output-clock ticks, so the `fbMark` period in `clk` cycles is that ratio times the post-divide ratio.
- R2: `postSel` sets the post-divide ratio as code 0 = 2, 1 = 4, 2 = 8, 3 = 16. `pixEn` is high for one `clk` cycle in each such period.
- R3: A `fbDivIn` value below 4 gives a ratio of 12. A new divider value takes effect only at the next feedback terminal count; the one reset captures is used until then.
- R4: `hsFallSel` = 0 makes rising edges of `hsyncIn` the reference; `hsFallSel` = 1 makes falling edges the reference. The other edge has no effect on the pump outputs.
- R5: A reference edge sets `pumpUp` and a feedback edge sets `pumpDn`. Each stays high until the other edge arrives, and then both clear together. They are never high at the same time.
- R6: With `pumpAlways` = 0, the pump coasts while the synchronized `vsyncIn` equals `coastHighSel`. While coasting, `pumpUp` and `pumpDn` are low and stay cleared. With `pumpAlways` = 1 there is no coasting.
- R7: `hsyncOut` and `vsyncOut` take the two-stage-synchronized sync inputs on each output-clock tick and hold between ticks.
- R8: `lockStat` rises after 16 consecutive non-coasting reference edges with no pump pulse wider than `lockTol` cycles. A wider pulse clears it at once.
- R9: `lockPin` follows `lockStat` when `lockPinEn` = 1 and is held low otherwise.
- R10: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncIn | input | 1 | Line reference input |
| vsyncIn | input | 1 | Frame reference input, used for coasting |
| fbDivIn | input | 12 | Feedback divider word; ratio is the word plus 8 |
| postSel | input | 2 | Post-divide code |
| hsFallSel | input | 1 | 1 selects falling reference edges |
| pumpAlways | input | 1 | 1 keeps the pump enabled at all times |
| coastHighSel | input | 1 | Frame-reference level at which the pump coasts |
| lockTol | input | 4 | Largest pump pulse width accepted as locked |
| lockPinEn | input | 1 | Enables the lock pin |
| pixEn | output | 1 | Output-clock tick |
| fbMark | output | 1 | Registered feedback terminal count |
| hsyncOut | output | 1 | Re-timed line sync |
| vsyncOut | output | 1 | Re-timed frame sync |
| pumpUp | output | 1 | Pump-up enable |
| pumpDn | output | 1 | Pump-down enable |
| lockStat | output | 1 | Lock status |
| lockPin | output | 1 | Gated lock indication |

## Verification
A feedback counter that wraps at the wrong place shows up as a shifted `fbMark`, and in one divider period it also moves the following `pumpDn` edge. A detector flip-flop stuck in the wrong state produces a pump pulse that is too long or missing within two cycles of the next edge. If the lock counter is wrong, `lockStat` changes state on the wrong reference edge. Because the bench model predicts every output on every cycle, any divergence is flagged in the cycle it first reaches a port.

// File: rtl/llpll_pkg.sv
`timescale 1ns/1ps
package llpll_pkg;
  // Strobes that the datapath hands to the loop control each cycle
  typedef struct packed {
    logic refEdge;   // selected reference edge seen
    logic fbEdge;    // feedback divider terminal count
    logic coast;     // pump must be held idle
  } loopStrb_t;
endpackage

// File: rtl/llpll_datapath.sv
`timescale 1ns/1ps
module llpll_datapath
  import llpll_pkg::*;
#(
  parameter int FB_W   = 12,
  parameter int POST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic [FB_W-1:0]   fbDivIn,
  input  logic [POST_W-1:0] postSel,
  input  logic              hsFallSel,
  input  logic              pumpAlways,
  input  logic              coastHighSel,
  output loopStrb_t         strb,
  output logic              pixEn,
  output logic              fbMark,
  output logic              hsyncOut,
  output logic              vsyncOut
);
  localparam int PC_W    = 1 << POST_W;
  localparam int RATIO_W = FB_W + 1;
  localparam logic [RATIO_W-1:0] RATIO_OFS = RATIO_W'(8);
  localparam logic [RATIO_W-1:0] RATIO_MIN = RATIO_W'(12);

  logic [PC_W-1:0]    postCnt;
  logic [PC_W:0]      postRatio;
  logic               tick;
  logic [RATIO_W-1:0] ratioReq, ratioNext, actRatio, fbCnt;
  logic               fbTerm;
  logic [2:0]         hsSync;
  logic [1:0]         vsSync;

  // Post-divider: one tick per output-clock period
  assign postRatio = (PC_W+1)'(2) << postSel;
  assign tick      = {1'b0, postCnt} >= (postRatio - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       postCnt <= '0;
    else if (tick) postCnt <= '0;
    else           postCnt <= postCnt + 1'b1;
  end

  // Feedback divider with clamp and terminal-count update
  assign ratioReq  = {1'b0, fbDivIn} + RATIO_OFS;
  assign ratioNext = (ratioReq < RATIO_MIN) ? RATIO_MIN : ratioReq;
  assign fbTerm    = tick && (fbCnt == actRatio - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fbCnt    <= '0;
      actRatio <= ratioNext;
      fbMark   <= 1'b0;
    end else begin
      fbMark <= fbTerm;
      if (fbTerm) begin
        fbCnt    <= '0;
        actRatio <= ratioNext;
      end else if (tick) begin
        fbCnt <= fbCnt + 1'b1;
      end
    end
  end

  // Synchronizers and re-timing onto output-clock ticks
  always_ff @(posedge clk) begin
    if (rst) begin
      hsSync   <= '0;
      vsSync   <= '0;
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
    end else begin
      hsSync <= {hsSync[1:0], hsyncIn};
      vsSync <= {vsSync[0], vsyncIn};
      if (tick) begin
        hsyncOut <= hsSync[1];
        vsyncOut <= vsSync[1];
      end
    end
  end

  assign strb.refEdge = hsFallSel ? (hsSync[2] & ~hsSync[1]) : (hsSync[1] & ~hsSync[2]);
  assign strb.fbEdge  = fbTerm;
  assign strb.coast   = ~pumpAlways & (vsSync[1] == coastHighSel);
  assign pixEn        = tick;

  assert_fb_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    fbCnt < actRatio);
  assert_ratio_floor_R3: assert property (@(posedge clk) disable iff (rst)
    actRatio >= RATIO_MIN);
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    pixEn |=> !pixEn);
  assert_retime_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(hsyncOut) |-> $past(tick));
endmodule

// File: rtl/llpll_control.sv
`timescale 1ns/1ps
module llpll_control
  import llpll_pkg::*;
#(
  parameter int TOL_W        = 4,
  parameter int LOCK_PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  loopStrb_t        strb,
  input  logic [TOL_W-1:0] lockTol,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             lockStat
);
  localparam int GOOD_W = $clog2(LOCK_PERIODS + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(LOCK_PERIODS);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_PERIODS - 1);

  logic             upSet, dnSet, pulse, viol;
  logic [TOL_W-1:0] errRun;
  logic [GOOD_W-1:0] goodCnt;

  assign upSet = pumpUp | strb.refEdge;
  assign dnSet = pumpDn | strb.fbEdge;
  assign pulse = pumpUp | pumpDn;
  assign viol  = pulse && (errRun >= lockTol);

  // Two-flip-flop phase-frequency detector
  always_ff @(posedge clk) begin
    if (rst || strb.coast || (upSet && dnSet)) begin
      pumpUp <= 1'b0;
      pumpDn <= 1'b0;
    end else begin
      pumpUp <= upSet;
      pumpDn <= dnSet;
    end
  end

  // Pulse-width measurement and lock qualification
  always_ff @(posedge clk) begin
    if (rst) begin
      errRun   <= '0;
      goodCnt  <= '0;
      lockStat <= 1'b0;
    end else begin
      if (!pulse)          errRun <= '0;
      else if (errRun != '1) errRun <= errRun + 1'b1;
      if (viol) begin
        goodCnt  <= '0;
        lockStat <= 1'b0;
      end else if (strb.refEdge && !strb.coast) begin
        if (goodCnt < GOOD_MAX)   goodCnt  <= goodCnt + 1'b1;
        if (goodCnt >= GOOD_LAST) lockStat <= 1'b1;
      end
    end
  end

  assert_pump_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(pumpUp && pumpDn));
  assert_coast_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    strb.coast |=> (!pumpUp && !pumpDn));
  assert_lock_on_ref_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(lockStat) |-> $past(strb.refEdge));
  assert_wide_pulse_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
    viol |=> !lockStat);
endmodule

// File: rtl/llpll_front.sv
`timescale 1ns/1ps
module llpll_front
  import llpll_pkg::*;
#(
  parameter int FB_W         = 12,
  parameter int POST_W       = 2,
  parameter int TOL_W        = 4,
  parameter int LOCK_PERIODS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic [FB_W-1:0]   fbDivIn,
  input  logic [POST_W-1:0] postSel,
  input  logic              hsFallSel,
  input  logic              pumpAlways,
  input  logic              coastHighSel,
  input  logic [TOL_W-1:0]  lockTol,
  input  logic              lockPinEn,
  output logic              pixEn,
  output logic              fbMark,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              pumpUp,
  output logic              pumpDn,
  output logic              lockStat,
  output logic              lockPin
);
  loopStrb_t strb;

  llpll_datapath #(.FB_W(FB_W), .POST_W(POST_W)) uDp (
    .clk(clk), .rst(rst), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .fbDivIn(fbDivIn), .postSel(postSel), .hsFallSel(hsFallSel),
    .pumpAlways(pumpAlways), .coastHighSel(coastHighSel), .strb(strb),
    .pixEn(pixEn), .fbMark(fbMark), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );

  llpll_control #(.TOL_W(TOL_W), .LOCK_PERIODS(LOCK_PERIODS)) uCtl (
    .clk(clk), .rst(rst), .strb(strb), .lockTol(lockTol),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .lockStat(lockStat)
  );

  assign lockPin = lockStat & lockPinEn;

  assert_pin_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !lockPinEn |-> !lockPin);
endmodule

// File: tb/tb_llpll_front.sv
`timescale 1ns/1ps
module tb_llpll_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic [11:0] fbDivIn = 12'd4;
  logic [1:0]  postSel = 2'd0;
  logic hsFallSel = 1'b0, pumpAlways = 1'b1, coastHighSel = 1'b0;
  logic [3:0] lockTol = 4'd15;
  logic lockPinEn = 1'b1;
  logic pixEn, fbMark, hsyncOut, vsyncOut, pumpUp, pumpDn, lockStat, lockPin;

  int nChecks = 0, nFail = 0;
  bit started = 0, finished = 0;

  always #4 clk = ~clk;

  llpll_front dut (
    .clk(clk), .rst(rst), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .fbDivIn(fbDivIn), .postSel(postSel), .hsFallSel(hsFallSel),
    .pumpAlways(pumpAlways), .coastHighSel(coastHighSel), .lockTol(lockTol),
    .lockPinEn(lockPinEn), .pixEn(pixEn), .fbMark(fbMark), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .pumpUp(pumpUp), .pumpDn(pumpDn), .lockStat(lockStat),
    .lockPin(lockPin)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int mPost, mFb, mAct, mErr, mGood;
  bit mH1, mH2, mH3, mV1, mV2, mHo, mVo, mUp, mDn, mLock, mMark;

  function automatic int ratioOf(input int w);
    return (w + 8 < 12) ? 12 : w + 8;
  endfunction

  always @(posedge clk) begin
    int n;
    bit tk, fbE, refE, co, nu, nd, pul, vio;
    started = 1;
    if (rst) begin
      mPost = 0; mFb = 0; mAct = ratioOf(int'(fbDivIn)); mErr = 0; mGood = 0;
      {mH1, mH2, mH3, mV1, mV2, mHo, mVo, mUp, mDn, mLock, mMark} = '0;
    end else begin
      n    = 2 << postSel;
      tk   = mPost >= n - 1;
      fbE  = tk && (mFb == mAct - 1);
      refE = hsFallSel ? (mH3 && !mH2) : (mH2 && !mH3);
      co   = !pumpAlways && (mV2 == coastHighSel);
      nu   = mUp || refE;
      nd   = mDn || fbE;
      pul  = mUp || mDn;
      vio  = pul && (mErr >= int'(lockTol));
      mPost = tk ? 0 : mPost + 1;
      if (fbE) begin mFb = 0; mAct = ratioOf(int'(fbDivIn)); end
      else if (tk) mFb = mFb + 1;
      mMark = fbE;
      if (tk) begin mHo = mH2; mVo = mV2; end
      mH3 = mH2; mH2 = mH1; mH1 = hsyncIn;
      mV2 = mV1; mV1 = vsyncIn;
      if (co || (nu && nd)) begin mUp = 0; mDn = 0; end
      else begin mUp = nu; mDn = nd; end
      if (!pul) mErr = 0;
      else if (mErr < 15) mErr = mErr + 1;
      if (vio) begin mGood = 0; mLock = 0; end
      else if (refE && !co) begin
        if (mGood >= 15) mLock = 1;
        if (mGood < 16) mGood = mGood + 1;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R2", "pixEn", int'(pixEn), int'(mPost >= (2 << postSel) - 1));
      check("R1", "fbMark", int'(fbMark), int'(mMark));
      check("R7", "hsyncOut", int'(hsyncOut), int'(mHo));
      check("R7", "vsyncOut", int'(vsyncOut), int'(mVo));
      check("R5", "pumpUp", int'(pumpUp), int'(mUp));
      check("R5", "pumpDn", int'(pumpDn), int'(mDn));
      check("R8", "lockStat", int'(lockStat), int'(mLock));
      check("R9", "lockPin", int'(lockPin), int'(mLock && lockPinEn));
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(posedge clk); #1 rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic markPeriod(output int per);
    do @(negedge clk); while (!fbMark);
    per = 0;
    do begin @(negedge clk); per++; end while (!fbMark);
  endtask

  task automatic tickPeriod(output int per);
    do @(negedge clk); while (!pixEn);
    per = 0;
    do begin @(negedge clk); per++; end while (!pixEn);
  endtask

  task automatic hsPulses(input int count, input int period, input int hi);
    for (int p = 0; p < count; p++)
      for (int c = 0; c < period; c++) begin
        @(posedge clk); #1 hsyncIn = (c < hi);
      end
  endtask

  initial begin
    int per;
    cyc(3);
    @(negedge clk);
    // R10: outputs quiet in reset
    check("R10", "reset outputs",
          int'({pixEn, fbMark, hsyncOut, vsyncOut, pumpUp, pumpDn, lockStat, lockPin}), 0);
    @(posedge clk); #1 rst = 1'b0;

    // R1: word 4 -> ratio 12, post /2 -> 24 clocks
    markPeriod(per); markPeriod(per);
    check("R1", "mark period w=4", per, 24);
    // R3: word below minimum clamps to ratio 12
    @(posedge clk); #1 fbDivIn = 12'd1;
    markPeriod(per); markPeriod(per);
    check("R3", "mark period w=1", per, 24);
    // R1 and R2: word 8 -> ratio 16, post /4 -> 64 clocks
    @(posedge clk); #1 fbDivIn = 12'd8; postSel = 2'd1;
    markPeriod(per); markPeriod(per);
    check("R1", "mark period w=8 /4", per, 64);
    @(posedge clk); #1 postSel = 2'd3;
    tickPeriod(per); tickPeriod(per);
    check("R2", "tick period code 3", per, 16);
    @(posedge clk); #1 postSel = 2'd2;
    tickPeriod(per); tickPeriod(per);
    check("R2", "tick period code 2", per, 8);

    // R8: matched reference acquires lock
    @(posedge clk); #1 postSel = 2'd0; fbDivIn = 12'd4;
    markPeriod(per); markPeriod(per);
    hsPulses(20, 24, 6);
    @(negedge clk);
    check("R8", "locked after matched periods", int'(lockStat), 1);
    check("R9", "pin follows lock", int'(lockPin), 1);
    @(posedge clk); #1 lockPinEn = 1'b0;
    @(negedge clk);
    check("R9", "pin held low when disabled", int'(lockPin), 0);
    @(posedge clk); #1 lockPinEn = 1'b1; lockTol = 4'd2;
    hsPulses(3, 24, 6);
    @(negedge clk);
    check("R8", "lock cleared by wide pulse", int'(lockStat), 0);

    // R4, R5, R6, R7 with a very long feedback period
    fbDivIn = 12'hFFF; postSel = 2'd3; hsFallSel = 1'b1; lockTol = 4'd15;
    doReset();
    hsyncIn = 1'b1; cyc(6);
    check("R4", "rising edge ignored when falling selected", int'(pumpUp), 0);
    hsyncIn = 1'b0; cyc(6);
    check("R4", "falling edge sets up", int'(pumpUp), 1);
    cyc(50);
    check("R5", "up holds without feedback edge", int'(pumpUp), 1);
    check("R5", "down stays low", int'(pumpDn), 0);
    pumpAlways = 1'b0; coastHighSel = 1'b0; vsyncIn = 1'b0; cyc(5);
    check("R6", "coast while frame ref low", int'(pumpUp), 0);
    vsyncIn = 1'b1; cyc(20);
    check("R6", "up stays cleared after coast", int'(pumpUp), 0);
    check("R7", "vsyncOut re-timed", int'(vsyncOut), 1);
    hsyncIn = 1'b1; cyc(20);
    check("R7", "hsyncOut re-timed", int'(hsyncOut), 1);
    hsyncIn = 1'b0; cyc(6);
    check("R6", "edge passes outside coast", int'(pumpUp), 1);
    coastHighSel = 1'b1; cyc(4);
    check("R6", "coast while frame ref high", int'(pumpUp), 0);
    pumpAlways = 1'b1; hsyncIn = 1'b1; cyc(4); hsyncIn = 1'b0; cyc(6);
    check("R6", "always-on ignores frame ref", int'(pumpUp), 1);

    cyc(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule